// File: doc/BRIEF.md
# Synthesizer Calibration Programming Sequencer

This block brings up a serially programmed frequency synthesizer and keeps it tuned. A `start` pulse begins a full load: the divider words, then a generated register table, then the main control word. The block then enables fast calibration and runs a fixed indexing routine of 23 writes. It starts calibration, waits a settle interval measured in clock cycles, ends calibration, and samples the lock-detect input. If the synthesizer has not locked, the block writes the device reset bit and repeats the whole load and calibration. It does this up to a parameterised number of times. After that it raises a sticky error.

Once lock is confirmed, the block reports `ready`. A `freq_req` pulse then rewrites only the divider words and the main control word, without a new calibration, so frequency changes are short. Every write is one 24-bit word: an 8-bit address followed by 16 data bits. Each word is sent by an instantiated serial shifter within its own chip-select frame.

Top module: `synth_cal_seq`

## Requirements
- R1: Each word goes out MSB first as exactly 24 bits inside one low period of `cs_n`. `mosi` is stable when `sclk` rises, and `sclk` is low whenever `cs_n` is high.
- R2: A full load sends seven divider words in this order: address 0x2D with cal_num[31:16], 0x2C with cal_num[15:0], 0x2B with frac_num[31:16], 0x2A with frac_num[15:0], 0x27 with frac_den[31:16], 0x26 with frac_den[15:0], 0x24 with n_div. It then sends table addresses TABLE_DEPTH-1 down to 1, where the word for address a is {a, 8-bit a*3, a XOR 0xC3}. It ends with the control word {0x00, R0_BASE}.
- R3: After the load, the block sends 0x4A0001 and then the index routine: 0x6A0400, 0x6B0000, 0x6C0000, 0x6D0000. For each index i from 514 to 519 it sends w = 0x6A0400|i, then w|0x0800, then w again. The routine finishes with 0x6A0207.
- R4: Calibration sends the control word with bit 4 set (R0_BASE|0x0010), and after the settle wait sends the plain control word.
- R5: The `cs_n` high gap before the calibration-end word is between SETTLE_CYCLES and SETTLE_CYCLES+6 clocks. Every other gap within a sequence is at most 4 clocks.
- R6: If `lock_det` is high after calibration, `ready` goes high, `busy` goes low and no further word is sent.
- R7: If lock is missing and retries remain, the block sends the control word with bit 1 set (R0_BASE|0x0002) and then repeats R2 to R4.
- R8: After MAX_RETRY+1 failed attempts, `error` goes high and stays high until the next accepted `start`. `ready` stays low and no reset word follows the last attempt.
- R9: An accepted `freq_req` sends the seven divider words of R2 with the newly presented values, then the plain control word, with no calibration words. `ready` returns high afterwards.
- R10: `freq_req` has no effect unless the block is ready and not busy. `start` has no effect while busy.
- R11: After reset `cs_n`=1, `sclk`=0, `busy`=0, `ready`=0 and `error`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse: begin full load and calibration |
| freq_req | input | 1 | Pulse: rewrite the divider words only |
| lock_det | input | 1 | Synthesizer lock indication |
| n_div | input | 16 | Integer divider value |
| frac_num | input | 32 | Fractional numerator |
| frac_den | input | 32 | Fractional denominator |
| cal_num | input | 32 | Fast-calibration numerator |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data |
| cs_n | output | 1 | Active-low chip select, one frame per word |
| busy | output | 1 | A sequence is running |
| ready | output | 1 | Lock confirmed and block idle |
| error | output | 1 | Sticky: retries exhausted |

## Verification
The assertions take it that `start` is only pulsed and that `lock_det` changes away from the clock edge. They also take it that `lock_det` changes no more than once per sequence, so that the sample taken at the lock check is what caused `error` to rise. The bench drives every input at the falling clock edge. It holds the divider values steady while a sequence runs. It changes `lock_det` only long before a lock check, either as a fixed level or once after it has seen the second calibration-start word. A stuck-unlocked run, a run that locks on the second attempt and a run that locks at once together exercise every retry outcome for a retry limit of two.

// File: rtl/synth_cal_pkg.sv
package synth_cal_pkg;
  localparam int WORD_W      = 24;
  localparam int DIV_WORDS   = 7;
  localparam int INDEX_WORDS = 23;
  localparam int CAL_BIT     = 4;
  localparam int RST_BIT     = 1;
  localparam logic [23:0] FASTCAL_EN_WORD = 24'h4A0001;

  typedef enum logic [3:0] {
    S_IDLE, S_LOAD, S_CALEN, S_INDEX, S_FCAL_ON, S_WAIT,
    S_FCAL_OFF, S_CHECK, S_RESET, S_FREQ
  } seq_state_t;

  typedef struct packed {
    logic [31:0] cal_num;
    logic [31:0] num;
    logic [31:0] den;
    logic [15:0] n;
  } div_cfg_t;

  // Divider words, sent highest address first.
  function automatic logic [23:0] div_word(input int idx, input div_cfg_t c);
    case (idx)
      0:       return {8'h2D, c.cal_num[31:16]};
      1:       return {8'h2C, c.cal_num[15:0]};
      2:       return {8'h2B, c.num[31:16]};
      3:       return {8'h2A, c.num[15:0]};
      4:       return {8'h27, c.den[31:16]};
      5:       return {8'h26, c.den[15:0]};
      default: return {8'h24, c.n};
    endcase
  endfunction

  // Index routine: four clears, six set/pulse/release triples, one final release.
  function automatic logic [23:0] index_word(input int s);
    int j;
    int k;
    logic [9:0] idx;
    if (s == 0) return 24'h6A0400;
    if (s == 1) return 24'h6B0000;
    if (s == 2) return 24'h6C0000;
    if (s == 3) return 24'h6D0000;
    if (s >= INDEX_WORDS - 1) return 24'h6A0207;
    j   = (s - 4) / 3;
    k   = (s - 4) % 3;
    idx = 10'(514 + j);
    return {8'h6A, 4'b0000, (k == 1), 1'b1, idx};
  endfunction
endpackage

// File: rtl/spi_word_tx.sv
module spi_word_tx #(
  parameter int WORD_W   = 24,
  parameter int HALF_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] word,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_n,
  output logic              done
);
  localparam int CNT_W = $clog2(HALF_DIV + 1);
  localparam int BIT_W = $clog2(WORD_W);

  logic              active;
  logic [WORD_W-1:0] sh;
  logic [CNT_W-1:0]  div_cnt;
  logic [BIT_W-1:0]  bit_cnt;

  assign mosi = sh[WORD_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      sh      <= '0;
      div_cnt <= '0;
      bit_cnt <= '0;
      sclk    <= 1'b0;
      cs_n    <= 1'b1;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start) begin
          active  <= 1'b1;
          sh      <= word;
          cs_n    <= 1'b0;
          div_cnt <= '0;
          bit_cnt <= '0;
        end
      end else if (int'(div_cnt) == HALF_DIV - 1) begin
        div_cnt <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
        end else begin
          sclk <= 1'b0;
          if (int'(bit_cnt) == WORD_W - 1) begin
            active <= 1'b0;
            cs_n   <= 1'b1;
            done   <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
            sh      <= {sh[WORD_W-2:0], 1'b0};
          end
        end
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfg_table.sv
module cfg_table (
  input  logic [7:0]  addr,
  output logic [23:0] word
);
  logic [7:0] mul3;
  assign mul3 = addr * 8'd3;
  assign word = {addr, mul3, addr ^ 8'hC3};
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  output logic expired
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      run     <= 1'b0;
      expired <= 1'b0;
    end else begin
      expired <= 1'b0;
      if (arm) begin
        cnt <= '0;
        run <= 1'b1;
      end else if (run) begin
        if (cnt == CW'(CYCLES - 1)) begin
          run     <= 1'b0;
          expired <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/synth_cal_seq.sv
module synth_cal_seq
  import synth_cal_pkg::*;
#(
  parameter int          TABLE_DEPTH   = 16,
  parameter int          SPI_HALF      = 4,
  parameter int          SETTLE_CYCLES = 10000000,
  parameter int          MAX_RETRY     = 3,
  parameter logic [15:0] R0_BASE       = 16'h6020
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        freq_req,
  input  logic        lock_det,
  input  logic [15:0] n_div,
  input  logic [31:0] frac_num,
  input  logic [31:0] frac_den,
  input  logic [31:0] cal_num,
  output logic        sclk,
  output logic        mosi,
  output logic        cs_n,
  output logic        busy,
  output logic        ready,
  output logic        error
);
  localparam int LOAD_LEN = DIV_WORDS + TABLE_DEPTH;
  localparam int MAX_LEN  = (LOAD_LEN > INDEX_WORDS) ? LOAD_LEN : INDEX_WORDS;
  localparam int STEP_W   = $clog2(MAX_LEN + 1);
  localparam int RW       = $clog2(MAX_RETRY + 2);
  localparam logic [23:0] R0_WORD = {8'h00, R0_BASE};

  seq_state_t        state;
  logic [STEP_W-1:0] step;
  logic [RW-1:0]     retry;
  div_cfg_t          cfg;
  logic              cal_ok;
  logic              inflight;
  logic              tx_start;
  logic [23:0]       tx_word;
  logic              tx_done;
  logic              arm;
  logic              expired;
  logic [7:0]        tbl_addr;
  logic [23:0]       tbl_word;
  logic [23:0]       cur_word;
  int                last_step;
  logic              sending;

  spi_word_tx #(.WORD_W(WORD_W), .HALF_DIV(SPI_HALF)) u_spi (
    .clk(clk), .rst(rst), .start(tx_start), .word(tx_word),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .done(tx_done)
  );

  cfg_table u_tbl (.addr(tbl_addr), .word(tbl_word));

  settle_timer #(.CYCLES(SETTLE_CYCLES)) u_tmr (
    .clk(clk), .rst(rst), .arm(arm), .expired(expired)
  );

  // Word selection for the current state and step.
  always_comb begin
    tbl_addr = 8'(TABLE_DEPTH - 1 - (int'(step) - DIV_WORDS));
    cur_word = R0_WORD;
    case (state)
      S_LOAD: begin
        if (int'(step) < DIV_WORDS)     cur_word = div_word(int'(step), cfg);
        else if (int'(step) < LOAD_LEN - 1) cur_word = tbl_word;
        else                             cur_word = R0_WORD;
      end
      S_CALEN:    cur_word = FASTCAL_EN_WORD;
      S_INDEX:    cur_word = index_word(int'(step));
      S_FCAL_ON:  cur_word = R0_WORD | (24'd1 << CAL_BIT);
      S_RESET:    cur_word = R0_WORD | (24'd1 << RST_BIT);
      S_FREQ: begin
        if (int'(step) < DIV_WORDS) cur_word = div_word(int'(step), cfg);
        else                        cur_word = R0_WORD;
      end
      default:    cur_word = R0_WORD;
    endcase
  end

  always_comb begin
    case (state)
      S_LOAD:  last_step = LOAD_LEN - 1;
      S_INDEX: last_step = INDEX_WORDS - 1;
      S_FREQ:  last_step = DIV_WORDS;
      default: last_step = 0;
    endcase
    sending = (state == S_LOAD) || (state == S_CALEN) || (state == S_INDEX) ||
              (state == S_FCAL_ON) || (state == S_FCAL_OFF) ||
              (state == S_RESET) || (state == S_FREQ);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      step     <= '0;
      retry    <= '0;
      cfg      <= '0;
      cal_ok   <= 1'b0;
      inflight <= 1'b0;
      tx_start <= 1'b0;
      tx_word  <= '0;
      arm      <= 1'b0;
      busy     <= 1'b0;
      ready    <= 1'b0;
      error    <= 1'b0;
    end else begin
      tx_start <= 1'b0;
      arm      <= 1'b0;
      if (state == S_IDLE) begin
        if (start) begin
          cfg    <= '{cal_num: cal_num, num: frac_num, den: frac_den, n: n_div};
          retry  <= '0;
          error  <= 1'b0;
          ready  <= 1'b0;
          cal_ok <= 1'b0;
          busy   <= 1'b1;
          step   <= '0;
          state  <= S_LOAD;
        end else if (freq_req && cal_ok) begin
          cfg   <= '{cal_num: cal_num, num: frac_num, den: frac_den, n: n_div};
          ready <= 1'b0;
          busy  <= 1'b1;
          step  <= '0;
          state <= S_FREQ;
        end
      end else if (sending) begin
        if (!inflight) begin
          tx_start <= 1'b1;
          tx_word  <= cur_word;
          inflight <= 1'b1;
        end else if (tx_done) begin
          inflight <= 1'b0;
          step     <= step + 1'b1;
          if (int'(step) == last_step) begin
            step <= '0;
            case (state)
              S_LOAD:     state <= S_CALEN;
              S_CALEN:    state <= S_INDEX;
              S_INDEX:    state <= S_FCAL_ON;
              S_FCAL_ON: begin
                state <= S_WAIT;
                arm   <= 1'b1;
              end
              S_FCAL_OFF: state <= S_CHECK;
              S_RESET:    state <= S_LOAD;
              default: begin
                state <= S_IDLE;
                busy  <= 1'b0;
                ready <= 1'b1;
              end
            endcase
          end
        end
      end else if (state == S_WAIT) begin
        if (expired) state <= S_FCAL_OFF;
      end else if (state == S_CHECK) begin
        if (lock_det) begin
          ready  <= 1'b1;
          cal_ok <= 1'b1;
          busy   <= 1'b0;
          state  <= S_IDLE;
        end else if (int'(retry) == MAX_RETRY) begin
          error <= 1'b1;
          busy  <= 1'b0;
          state <= S_IDLE;
        end else begin
          retry <= retry + 1'b1;
          state <= S_RESET;
        end
      end else begin
        state <= S_IDLE;
      end
    end
  end
endmodule

// File: rtl/synth_cal_seq_chk.sv
module synth_cal_seq_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic lock_det,
  input logic cs_n,
  input logic sclk,
  input logic busy,
  input logic ready,
  input logic error
);
  // R1: serial clock parked low outside a frame
  p_sclk_park_r1: assert property (@(posedge clk) disable iff (rst) cs_n |-> !sclk);
  // R6: ready only when no sequence runs
  p_ready_idle_r6: assert property (@(posedge clk) disable iff (rst) busy |-> !ready);
  // R8: error and ready never together
  p_err_excl_r8: assert property (@(posedge clk) disable iff (rst) !(ready && error));
  // R8: error holds until a start
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst) (error && !start) |=> error);
  // R8: error only rises from a failed lock sample
  p_err_cause_r8: assert property (@(posedge clk) disable iff (rst) $rose(error) |-> !$past(lock_det));
  // R10: no frame while idle
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst) !busy |-> cs_n);
endmodule

bind synth_cal_seq synth_cal_seq_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .lock_det(lock_det), .cs_n(cs_n),
  .sclk(sclk), .busy(busy), .ready(ready), .error(error)
);

// File: tb/sim_synth_cal_seq.sv
module sim_synth_cal_seq;
  localparam int DEPTH  = 4;
  localparam int SETTLE = 20;
  localparam int RETRY  = 2;
  localparam logic [23:0] R0  = 24'h006020;
  localparam logic [23:0] CON = 24'h006030;
  localparam logic [23:0] RSTW = 24'h006022;

  logic clk = 0, rst = 1, start = 0, freq_req = 0;
  logic [15:0] n_div = 0;
  logic [31:0] frac_num = 0, frac_den = 0, cal_num = 0;
  logic sclk, mosi, cs_n, busy, ready, error, lock_det;
  int lock_policy = 0;
  logic lock_val = 0;
  int calon_cnt = 0;

  assign lock_det = (lock_policy == 0) ? lock_val : (calon_cnt >= 2);

  always #4 clk = ~clk;

  synth_cal_seq #(.TABLE_DEPTH(DEPTH), .SPI_HALF(2), .SETTLE_CYCLES(SETTLE),
                  .MAX_RETRY(RETRY), .R0_BASE(16'h6020)) u0 (
    .clk(clk), .rst(rst), .start(start), .freq_req(freq_req), .lock_det(lock_det),
    .n_div(n_div), .frac_num(frac_num), .frac_den(frac_den), .cal_num(cal_num),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .busy(busy), .ready(ready), .error(error));

  int nchk = 0, nfail = 0;
  logic [23:0] cap [0:511];
  int capb [0:511];
  int capg [0:511];
  int ncap = 0;
  logic [23:0] expw [0:511];
  int nexp = 0;

  // serial monitor, sampled at the falling clock edge
  logic [23:0] sh = 0;
  int nb = 0, hcnt = 0, cur_gap = 0;
  logic prev_cs = 1, prev_sclk = 0;
  always @(negedge clk) begin
    if (cs_n) hcnt++;
    if (!cs_n && prev_cs) begin cur_gap = hcnt; hcnt = 0; nb = 0; end
    if (sclk && !prev_sclk) begin sh = {sh[22:0], mosi}; nb++; end
    if (cs_n && !prev_cs && ncap < 512) begin
      cap[ncap] = sh; capb[ncap] = nb; capg[ncap] = cur_gap; ncap++;
      if (sh == CON) calon_cnt++;
    end
    prev_cs = cs_n; prev_sclk = sclk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [23:0] w);
    expw[nexp] = w; nexp++;
  endtask

  task automatic exp_div(input logic [31:0] cn, input logic [31:0] nm, input logic [31:0] dn,
                         input logic [15:0] n);
    push({8'h2D, cn[31:16]}); push({8'h2C, cn[15:0]});
    push({8'h2B, nm[31:16]}); push({8'h2A, nm[15:0]});
    push({8'h27, dn[31:16]}); push({8'h26, dn[15:0]});
    push({8'h24, n});
  endtask

  task automatic exp_attempt();
    logic [7:0] a, m;
    logic [23:0] w;
    exp_div(cal_num, frac_num, frac_den, n_div);
    for (int i = DEPTH - 1; i >= 1; i--) begin
      a = 8'(i); m = 8'(i * 3);
      push({a, m, a ^ 8'hC3});
    end
    push(R0);
    push(24'h4A0001);
    push(24'h6A0400); push(24'h6B0000); push(24'h6C0000); push(24'h6D0000);
    for (int i = 514; i <= 519; i++) begin
      w = 24'h6A0400 | 24'(i);
      push(w); push(w | 24'h000800); push(w);
    end
    push(24'h6A0207);
    push(CON);
    push(R0);
  endtask

  task automatic compare(input string req);
    chk(ncap == nexp, req, ncap, nexp);
    for (int i = 0; i < nexp && i < ncap; i++) begin
      chk(cap[i] == expw[i], req, int'(cap[i]), int'(expw[i]));
      chk(capb[i] == 24, "R1 bit count", capb[i], 24);
      if (i > 0) begin
        if (expw[i-1] == CON)
          chk(capg[i] >= SETTLE && capg[i] <= SETTLE + 6, "R5 settle gap", capg[i], SETTLE);
        else
          chk(capg[i] <= 4, "R5 word gap", capg[i], 4);
      end
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic pulse_freq();
    @(negedge clk) freq_req = 1;
    @(negedge clk) freq_req = 0;
  endtask

  task automatic wait_idle();
    int t = 0;
    while (!busy && t < 20) begin @(negedge clk); t++; end
    t = 0;
    while (busy && t < 60000) begin @(negedge clk); t++; end
    repeat (5) @(negedge clk);
  endtask

  task automatic clear();
    ncap = 0; nexp = 0; calon_cnt = 0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    chk(cs_n == 1 && sclk == 0, "R11 serial idle", {cs_n, sclk}, 2);
    chk(busy == 0 && ready == 0 && error == 0, "R11 flags", {busy, ready, error}, 0);

    // R10: frequency request before calibration does nothing
    clear();
    pulse_freq();
    repeat (200) @(negedge clk);
    chk(ncap == 0 && busy == 0, "R10 freq before cal", ncap, 0);

    // R2 R3 R4 R6: lock at first attempt; R10 requests while busy are ignored
    cal_num = 32'h1234_5678; frac_num = 32'h0000_1000; frac_den = 32'h0001_0000; n_div = 16'h0070;
    lock_policy = 0; lock_val = 1;
    clear();
    exp_attempt();
    pulse_start();
    repeat (300) @(negedge clk);
    pulse_freq();
    pulse_start();
    wait_idle();
    compare("R2 R3 R4 R6 R10 first-lock stream");
    chk(ready == 1 && error == 0 && busy == 0, "R6 ready after lock", {ready, error, busy}, 4);

    // R9: frequency change rewrites dividers only
    cal_num = 32'hCAFE_0042; frac_num = 32'h0000_7777; frac_den = 32'h00FF_FFFF; n_div = 16'h0085;
    clear();
    exp_div(cal_num, frac_num, frac_den, n_div);
    push(R0);
    pulse_freq();
    wait_idle();
    compare("R9 freq change stream");
    chk(ready == 1 && busy == 0, "R9 ready after change", {ready, busy}, 2);

    // R7: lock on the second attempt after one reset word
    lock_policy = 1;
    clear();
    exp_attempt(); push(RSTW); exp_attempt();
    pulse_start();
    wait_idle();
    compare("R7 retry stream");
    chk(ready == 1 && error == 0, "R7 ready after retry", {ready, error}, 2);

    // R8: never locks; attempts = RETRY+1, no trailing reset word
    lock_policy = 0; lock_val = 0;
    clear();
    for (int k = 0; k <= RETRY; k++) begin
      exp_attempt();
      if (k < RETRY) push(RSTW);
    end
    pulse_start();
    wait_idle();
    compare("R8 exhausted stream");
    chk(error == 1 && ready == 0 && busy == 0, "R8 error state", {error, ready, busy}, 4);
    repeat (50) @(negedge clk);
    chk(error == 1, "R8 error sticky", error, 1);

    // R10: frequency request while errored is ignored
    clear();
    pulse_freq();
    repeat (200) @(negedge clk);
    chk(ncap == 0 && busy == 0, "R10 freq after error", ncap, 0);

    // R8: new start clears error and relocks
    lock_val = 1;
    clear();
    exp_attempt();
    pulse_start();
    @(negedge clk);
    chk(error == 0, "R8 error cleared by start", error, 0);
    wait_idle();
    compare("R6 relock stream");
    chk(ready == 1 && error == 0, "R6 ready after relock", {ready, error}, 2);

    summary();
    $finish;
  end
endmodule